// File: doc/BRIEF.md
# Clock Synthesizer Divider Fabric

This block is the digital divider fabric of a PLL-based clock distributor. It runs on the fast oscillator clock. The reference clock, the SPI clock, the SPI chip select and the SPI data line are all sampled into that one domain. Two 10-bit pre-dividers produce the strobes that feed the phase detector. The reference pre-divider counts reference rising edges. The feedback pre-divider counts pulses from a power-of-two post-divider, which runs on the oscillator. Five output dividers each produce a square clock with their own half-period and their own enable.

Four configuration registers hold every setting. They reset to values that need no software at all: every output runs, and the loop locks when the reference is one eighth of the oscillator. Writes arrive as 32-bit SPI frames. A reference monitor raises a holdover flag when the reference stops for too many feedback strobes, and drops it on the next reference edge.

Top module: `clksyn_divider_bank`

## Requirements
- R1: From reset, the phase-detector strobes, all outputs and the holdover flag are low. The defaults are: reference pre-divide 1, feedback pre-divide 8, post-select 0, output half-periods 1, 2, 4, 8 and 16, all outputs enabled, loss limit 100. With these defaults the feedback strobe period is 8 oscillator cycles.
- R2: An SPI frame is 32 bits, MSB first, sampled on SCLK rising while chip select is low. Bits 31:30 are the register address and bits 29:0 are the data. The frame takes effect when chip select rises. Register 0 holds reference pre-divide [9:0], feedback pre-divide [19:10] and post-select [22:20]. Register 1 holds output 0/1/2 half-periods at [9:0], [19:10] and [29:20]. Register 2 holds output 3/4 half-periods at [9:0] and [19:10], and enables for outputs 0..4 at [24:20]. Register 3 holds the loss limit at [6:0].
- R3: A frame with any bit count other than 32 leaves every register unchanged.
- R4: `pfd_ref_o` pulses for one cycle on every R-th synchronized reference rising edge, where R is the reference pre-divide. A value of 0 means 1024.
- R5: Post-select values 0 to 4 divide the oscillator by 1, 2, 4, 8 and 16. Any value above 4 divides by 16.
- R6: `pfd_fb_o` pulses for one cycle on every F-th post-divider pulse, where F is the feedback pre-divide. A value of 0 means 1024.
- R7: Each output toggles every N oscillator cycles, where N is its half-period field. A value of 0 means 1024.
- R8: A disabled output finishes any high phase in progress, then stays low. A re-enabled output starts from low and first rises after N cycles.
- R9: `holdover_o` rises once L feedback strobes have been counted with no reference rising edge in between. L is the loss limit, and 0 means 128.
- R10: `holdover_o` clears on the next synchronized reference rising edge.
- R11: Each asynchronous input passes through two sampling flops. A reference rise driven between clock edges shows on `pfd_ref_o` (with R=1) after the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock, sampled |
| spi_sclk_i | input | 1 | SPI serial clock, sampled |
| spi_cs_ni | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | SPI write data |
| pfd_ref_o | output | 1 | Divided reference strobe |
| pfd_fb_o | output | 1 | Divided feedback strobe |
| clk_out_o | output | 5 | Divided output clocks |
| holdover_o | output | 1 | Reference lost |

## Verification
The assertions take two things for granted. First, every level on the reference, SCLK, chip-select and data inputs lasts at least two oscillator cycles, so that no edge is lost in sampling. Second, chip select never rises in the same sampled cycle as an SCLK rising edge. The stimulus keeps within these limits. It holds each SCLK level and each data bit for four oscillator cycles. It pads chip select by four cycles on each side of a frame. It toggles the reference no faster than every four cycles.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
  localparam int unsigned DIV_W    = 10;
  localparam int unsigned NUM_OUT  = 5;
  localparam int unsigned FRAME_W  = 32;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned DATA_W   = FRAME_W - ADDR_W;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned POST_LOG = 4;
  localparam int unsigned LOSS_W   = 7;

  typedef struct packed {
    logic [DIV_W-1:0]              ref_div;
    logic [DIV_W-1:0]              fb_div;
    logic [SEL_W-1:0]              post_sel;
    logic [NUM_OUT-1:0][DIV_W-1:0] out_div;
    logic [NUM_OUT-1:0]            out_en;
    logic [LOSS_W-1:0]             loss_lim;
  } cfg_t;

  localparam cfg_t CFG_RST = '{
    ref_div:  DIV_W'(1),
    fb_div:   DIV_W'(8),
    post_sel: SEL_W'(0),
    out_div:  {DIV_W'(16), DIV_W'(8), DIV_W'(4), DIV_W'(2), DIV_W'(1)},
    out_en:   {NUM_OUT{1'b1}},
    loss_lim: LOSS_W'(100)
  };
endpackage

// File: rtl/clksyn_sync.sv
module clksyn_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= {STAGES{RST_VAL}};
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/clksyn_spi_regs.sv
module clksyn_spi_regs
  import clksyn_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_rise_i,
  input  logic cs_lvl_i,
  input  logic cs_rise_i,
  input  logic mosi_i,
  output cfg_t cfg_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               commit;
  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  data;
  cfg_t               cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (cs_lvl_i) begin
      cnt_q <= '0;
    end else if (sclk_rise_i) begin
      shift_q <= {shift_q[FRAME_W-2:0], mosi_i};
      if (cnt_q != OVER) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign commit = cs_rise_i && (cnt_q == FULL);
  assign addr   = shift_q[FRAME_W-1 -: ADDR_W];
  assign data   = shift_q[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
    end else if (commit) begin
      unique case (addr)
        2'd0: begin
          cfg_q.ref_div  <= data[9:0];
          cfg_q.fb_div   <= data[19:10];
          cfg_q.post_sel <= data[22:20];
        end
        2'd1: begin
          cfg_q.out_div[0] <= data[9:0];
          cfg_q.out_div[1] <= data[19:10];
          cfg_q.out_div[2] <= data[29:20];
        end
        2'd2: begin
          cfg_q.out_div[3] <= data[9:0];
          cfg_q.out_div[4] <= data[19:10];
          cfg_q.out_en     <= data[24:20];
        end
        default: cfg_q.loss_lim <= data[6:0];
      endcase
    end
  end

  assign cfg_o = cfg_q;

  AST_CFG_ONLY_AT_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> $past(cs_rise_i)); // R2
endmodule

// File: rtl/clksyn_prediv.sv
module clksyn_prediv #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         event_i,
  input  logic [W-1:0] div_i,
  output logic         pulse_o
);
  localparam int unsigned LIM_W = W + 1;

  logic [LIM_W-1:0] lim;
  logic [W-1:0]     cnt_q;
  logic             pulse_q;

  assign lim = (div_i == '0) ? (LIM_W'(1) << W) : {1'b0, div_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (event_i) begin
      if ({1'b0, cnt_q} >= lim - LIM_W'(1)) begin
        cnt_q   <= '0;
        pulse_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        pulse_q <= 1'b0;
      end
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;

  AST_PULSE_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(event_i)); // R4
endmodule

// File: rtl/clksyn_postdiv.sv
module clksyn_postdiv #(
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned MAX_LOG = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pulse_o
);
  logic [SEL_W-1:0]   k;
  logic [MAX_LOG:0]   one_hot;
  logic [MAX_LOG-1:0] mask;
  logic [MAX_LOG-1:0] cnt_q;

  assign k       = (sel_i > SEL_W'(MAX_LOG)) ? SEL_W'(MAX_LOG) : sel_i;
  assign one_hot = (MAX_LOG+1)'(1) << k;
  assign mask    = MAX_LOG'(one_hot - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign pulse_o = (cnt_q & mask) == mask;
endmodule

// File: rtl/clksyn_outdiv.sv
module clksyn_outdiv #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         clk_o
);
  localparam int unsigned LIM_W = W + 1;

  logic [LIM_W-1:0] lim;
  logic [W-1:0]     cnt_q;
  logic             clk_q;

  assign lim = (div_i == '0) ? (LIM_W'(1) << W) : {1'b0, div_i};

  // stop only while low, so a high phase always completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!en_i && !clk_q) begin
      cnt_q <= '0;
    end else if ({1'b0, cnt_q} >= lim - LIM_W'(1)) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_o = clk_q;

  AST_NO_RISE_WHILE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o) |-> $past(en_i)); // R8
endmodule

// File: rtl/clksyn_refmon.sv
module clksyn_refmon #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ref_edge_i,
  input  logic         fb_pulse_i,
  input  logic [W-1:0] lim_i,
  output logic         hold_o
);
  localparam int unsigned CNT_W = W + 1;

  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q;
  logic             hold_q;

  assign lim = (lim_i == '0) ? (CNT_W'(1) << W) : {1'b0, lim_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else if (ref_edge_i) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else if (fb_pulse_i && !hold_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q + 1'b1 >= lim) hold_q <= 1'b1;
    end
  end

  assign hold_o = hold_q;

  AST_HOLD_SET_ON_FB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(fb_pulse_i)); // R9
  AST_HOLD_CLR_ON_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> $past(ref_edge_i)); // R10
endmodule

// File: rtl/clksyn_divider_bank.sv
module clksyn_divider_bank
  import clksyn_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_clk_i,
  input  logic               spi_sclk_i,
  input  logic               spi_cs_ni,
  input  logic               spi_mosi_i,
  output logic               pfd_ref_o,
  output logic               pfd_fb_o,
  output logic [NUM_OUT-1:0] clk_out_o,
  output logic               holdover_o
);
  localparam int unsigned LANES = 4;
  localparam int unsigned L_REF = 0;
  localparam int unsigned L_SCK = 1;
  localparam int unsigned L_CS  = 2;
  localparam int unsigned L_MO  = 3;
  localparam logic [LANES-1:0] LANE_RST = LANES'(1) << L_CS;

  logic [LANES-1:0] sync_q;
  logic [L_CS:0]    prev_q;
  logic             ref_rise, sclk_rise, cs_rise, post_pulse;
  cfg_t             cfg;

  clksyn_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES), .RST_VAL(LANE_RST)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({spi_mosi_i, spi_cs_ni, spi_sclk_i, ref_clk_i}),
    .q_o (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= LANE_RST[L_CS:0];
    else         prev_q <= sync_q[L_CS:0];
  end

  assign ref_rise  = sync_q[L_REF] & ~prev_q[L_REF];
  assign sclk_rise = sync_q[L_SCK] & ~prev_q[L_SCK];
  assign cs_rise   = sync_q[L_CS]  & ~prev_q[L_CS];

  clksyn_spi_regs u_regs (
    .clk_i, .rst_ni,
    .sclk_rise_i (sclk_rise),
    .cs_lvl_i    (sync_q[L_CS]),
    .cs_rise_i   (cs_rise),
    .mosi_i      (sync_q[L_MO]),
    .cfg_o       (cfg)
  );

  clksyn_prediv #(.W(DIV_W)) u_ref_div (
    .clk_i, .rst_ni,
    .event_i (ref_rise),
    .div_i   (cfg.ref_div),
    .pulse_o (pfd_ref_o)
  );

  clksyn_postdiv #(.SEL_W(SEL_W), .MAX_LOG(POST_LOG)) u_post (
    .clk_i, .rst_ni,
    .sel_i   (cfg.post_sel),
    .pulse_o (post_pulse)
  );

  clksyn_prediv #(.W(DIV_W)) u_fb_div (
    .clk_i, .rst_ni,
    .event_i (post_pulse),
    .div_i   (cfg.fb_div),
    .pulse_o (pfd_fb_o)
  );

  clksyn_refmon #(.W(LOSS_W)) u_mon (
    .clk_i, .rst_ni,
    .ref_edge_i (ref_rise),
    .fb_pulse_i (pfd_fb_o),
    .lim_i      (cfg.loss_lim),
    .hold_o     (holdover_o)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    clksyn_outdiv #(.W(DIV_W)) u_div (
      .clk_i, .rst_ni,
      .en_i  (cfg.out_en[i]),
      .div_i (cfg.out_div[i]),
      .clk_o (clk_out_o[i])
    );
  end
endmodule

// File: tb/tb_clksyn_divider_bank.sv
`timescale 1ns/1ps
module tb_clksyn_divider_bank;
  localparam time CLK_PERIOD = 10ns;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic ref_gen = 1'b0, ref_man = 1'b0, ref_run = 1'b0, ref_i;
  logic pfd_ref_o, pfd_fb_o, holdover_o;
  logic [4:0] clk_out_o;
  int checks = 0, failures = 0;
  bit cmp_on = 0;

  assign ref_i = ref_run ? ref_gen : ref_man;
  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  clksyn_divider_bank dut (
    .clk_i, .rst_ni, .ref_clk_i(ref_i), .spi_sclk_i(spi_sclk), .spi_cs_ni(spi_cs_n),
    .spi_mosi_i(spi_mosi), .pfd_ref_o, .pfd_fb_o, .clk_out_o, .holdover_o);

  int rcnt = 0;
  always @(negedge clk_i) begin
    if (ref_run) begin
      if (rcnt == 3) begin ref_gen <= ~ref_gen; rcnt = 0; end
      else rcnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, one step per clock
  logic [2:0] h_ref, h_sck, h_cs, h_mo;
  int m_refdiv, m_fbdiv, m_sel, m_lim, m_odiv[5];
  bit m_oen[5], m_ov[5];
  int m_oc[5];
  int m_pc, m_rc, m_fc, m_lc, m_bc;
  bit m_rp, m_fp, m_hold;
  logic [31:0] m_sh;

  function automatic int lim10(input int v); return (v == 0) ? 1024 : v; endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_ref = 0; h_sck = 0; h_cs = 3'b111; h_mo = 0;
      m_refdiv = 1; m_fbdiv = 8; m_sel = 0; m_lim = 100;
      m_odiv = '{1, 2, 4, 8, 16};
      for (int i = 0; i < 5; i++) begin m_oen[i] = 1; m_ov[i] = 0; m_oc[i] = 0; end
      m_pc = 0; m_rc = 0; m_fc = 0; m_lc = 0; m_bc = 0;
      m_rp = 0; m_fp = 0; m_hold = 0; m_sh = 0;
    end else begin
      bit rr, sr, cr, pp;
      int k, llim;
      rr = h_ref[1] & ~h_ref[2];
      sr = h_sck[1] & ~h_sck[2];
      cr = h_cs[1] & ~h_cs[2];
      k = (m_sel > 4) ? 4 : m_sel;
      pp = ((m_pc % (1 << k)) == (1 << k) - 1);
      m_pc = (m_pc + 1) % 16;
      llim = (m_lim == 0) ? 128 : m_lim;
      if (rr) begin m_lc = 0; m_hold = 0; end
      else if (m_fp && !m_hold) begin m_lc++; if (m_lc >= llim) m_hold = 1; end
      if (rr) begin
        if (m_rc >= lim10(m_refdiv) - 1) begin m_rc = 0; m_rp = 1; end
        else begin m_rc++; m_rp = 0; end
      end else m_rp = 0;
      if (pp) begin
        if (m_fc >= lim10(m_fbdiv) - 1) begin m_fc = 0; m_fp = 1; end
        else begin m_fc++; m_fp = 0; end
      end else m_fp = 0;
      for (int i = 0; i < 5; i++) begin
        if (!m_oen[i] && !m_ov[i]) m_oc[i] = 0;
        else if (m_oc[i] >= lim10(m_odiv[i]) - 1) begin m_oc[i] = 0; m_ov[i] = !m_ov[i]; end
        else m_oc[i]++;
      end
      if (cr && m_bc == 32) begin
        case (m_sh[31:30])
          2'd0: begin m_refdiv = m_sh[9:0]; m_fbdiv = m_sh[19:10]; m_sel = m_sh[22:20]; end
          2'd1: begin m_odiv[0] = m_sh[9:0]; m_odiv[1] = m_sh[19:10]; m_odiv[2] = m_sh[29:20]; end
          2'd2: begin
            m_odiv[3] = m_sh[9:0]; m_odiv[4] = m_sh[19:10];
            for (int i = 0; i < 5; i++) m_oen[i] = m_sh[20+i];
          end
          default: m_lim = m_sh[6:0];
        endcase
      end
      if (h_cs[1]) m_bc = 0;
      else if (sr) begin m_sh = {m_sh[30:0], h_mo[1]}; if (m_bc != 33) m_bc++; end
      h_ref = {h_ref[1:0], ref_i};
      h_sck = {h_sck[1:0], spi_sclk};
      h_cs  = {h_cs[1:0], spi_cs_n};
      h_mo  = {h_mo[1:0], spi_mosi};
    end
  end

  always @(negedge clk_i) begin
    if (cmp_on && rst_ni) begin
      check(pfd_ref_o == m_rp, "R4 pfd_ref", int'(pfd_ref_o), int'(m_rp));
      check(pfd_fb_o == m_fp, "R6 pfd_fb", int'(pfd_fb_o), int'(m_fp));
      check(holdover_o == m_hold, "R9 holdover", int'(holdover_o), int'(m_hold));
      for (int i = 0; i < 5; i++)
        check(clk_out_o[i] == m_ov[i], "R7 clk_out", int'(clk_out_o[i]), int'(m_ov[i]));
    end
  end

  task automatic spi_send(input logic [1:0] addr, input logic [29:0] data, input int nbits);
    logic [31:0] frame;
    frame = {addr, data};
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk_i);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 32) ? frame[31-i] : 1'b0;
      repeat (4) @(negedge clk_i);
      spi_sclk = 1'b1;
      repeat (4) @(negedge clk_i);
      spi_sclk = 1'b0;
    end
    repeat (4) @(negedge clk_i);
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk_i);
  endtask

  task automatic measure_high(input int idx, output int n);
    while (clk_out_o[idx] !== 1'b0) @(negedge clk_i);
    while (clk_out_o[idx] !== 1'b1) @(negedge clk_i);
    n = 0;
    while (clk_out_o[idx] === 1'b1) begin n++; @(negedge clk_i); end
  endtask

  task automatic measure_gap(input bit fb, output int n);
    while ((fb ? pfd_fb_o : pfd_ref_o) !== 1'b1) @(negedge clk_i);
    n = 0;
    do begin @(negedge clk_i); n++; end while ((fb ? pfd_fb_o : pfd_ref_o) !== 1'b1);
  endtask

  initial begin
    int n, bad;
    repeat (3) @(negedge clk_i);
    check(pfd_ref_o == 0 && pfd_fb_o == 0, "R1 reset strobes", int'(pfd_ref_o | pfd_fb_o), 0);
    check(clk_out_o == 5'b0, "R1 reset outputs", int'(clk_out_o), 0);
    check(holdover_o == 0, "R1 reset holdover", int'(holdover_o), 0);
    rst_ni = 1'b1;
    cmp_on = 1;
    ref_run = 1'b1;
    repeat (400) @(negedge clk_i);
    measure_high(0, n); check(n == 1, "R1 out0 default", n, 1);
    measure_high(2, n); check(n == 4, "R1 out2 default", n, 4);
    measure_high(4, n); check(n == 16, "R1 out4 default", n, 16);
    measure_gap(1, n); check(n == 8, "R1 R6 fb gap default", n, 8);
    measure_gap(0, n); check(n == 8, "R6 ref gap equals fb gap", n, 8);
    check(holdover_o == 0, "R9 no holdover while locked", int'(holdover_o), 0);

    spi_send(2'd0, {7'd0, 3'd7, 10'd2, 10'd3}, 32);
    measure_gap(1, n); measure_gap(1, n); check(n == 32, "R5 sel above 4 divides by 16", n, 32);
    measure_gap(0, n); measure_gap(0, n); check(n == 24, "R4 ref pre-divide 3", n, 24);
    spi_send(2'd0, {7'd0, 3'd2, 10'd3, 10'd0}, 32);
    measure_gap(1, n); measure_gap(1, n); check(n == 12, "R5 sel 2 with fb 3", n, 12);
    measure_gap(0, n); measure_gap(0, n); check(n == 8192, "R4 ref zero means 1024", n, 8192);
    spi_send(2'd0, {7'd0, 3'd0, 10'd8, 10'd1}, 32);

    spi_send(2'd1, {10'd5, 10'd3, 10'd0}, 32);
    measure_high(1, n); check(n == 3, "R2 out1 written", n, 3);
    measure_high(2, n); check(n == 5, "R2 out2 written", n, 5);
    measure_high(0, n); measure_high(0, n); check(n == 1024, "R7 zero means 1024", n, 1024);

    spi_send(2'd1, {10'd5, 10'd7, 10'd1}, 31);
    measure_high(1, n); check(n == 3, "R3 short frame ignored", n, 3);
    spi_send(2'd1, {10'd5, 10'd7, 10'd1}, 33);
    measure_high(1, n); check(n == 3, "R3 long frame ignored", n, 3);

    spi_send(2'd2, {5'd0, 5'b10101, 10'd16, 10'd8}, 32);
    repeat (40) @(negedge clk_i);
    bad = 0;
    for (int c = 0; c < 100; c++) begin
      if (clk_out_o[1] || clk_out_o[3]) bad++;
      @(negedge clk_i);
    end
    check(bad == 0, "R8 disabled outputs stay low", bad, 0);
    spi_send(2'd2, {5'd0, 5'b11111, 10'd16, 10'd8}, 32);
    measure_high(3, n); check(n == 8, "R8 re-enabled half period", n, 8);

    ref_run = 1'b0; ref_man = 1'b0;
    repeat (700) @(negedge clk_i);
    check(holdover_o == 0, "R9 not yet 100 strobes", int'(holdover_o), 0);
    repeat (300) @(negedge clk_i);
    check(holdover_o == 1, "R9 holdover after 100 strobes", int'(holdover_o), 1);
    ref_man = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    check(pfd_ref_o == 0, "R11 no strobe after two edges", int'(pfd_ref_o), 0);
    @(negedge clk_i);
    check(pfd_ref_o == 1, "R11 strobe after third edge", int'(pfd_ref_o), 1);
    check(holdover_o == 0, "R10 cleared by ref edge", int'(holdover_o), 0);
    ref_man = 1'b0;
    ref_run = 1'b1;
    spi_send(2'd3, 30'd5, 32);
    ref_run = 1'b0;
    repeat (20) @(negedge clk_i);
    check(holdover_o == 0, "R9 limit 5 not reached", int'(holdover_o), 0);
    repeat (50) @(negedge clk_i);
    check(holdover_o == 1, "R9 limit 5 reached", int'(holdover_o), 1);
    ref_run = 1'b1;
    repeat (30) @(negedge clk_i);
    check(holdover_o == 0, "R10 cleared after restart", int'(holdover_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk_i);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule